// File: doc/BRIEF.md
# Round, Saturate and Format Output Stage

This block sits at the end of a filter datapath. It takes a wide signed accumulator value and turns it into a 16-bit output word. A 3-bit select code picks how many low bits of that word are dropped. The stage rounds to the nearest value at the kept precision, clamps the result so that it never wraps, and then encodes it in one of three number formats. The formatted word is captured in a register on every rising clock edge.

Alongside the data word the block produces a per-bit drive mask that an enclosing pad ring can use as tristate enables. The mask marks which bits are active: only the bits above the rounding point are driven, so the active width runs from 8 to 16 bits. The active-low output enable acts asynchronously on the mask. When it is high, every driver is switched off at once, without waiting for a clock edge.

The accumulator is read as a fixed-point value with `FRAC_W` fraction bits below bit 0 of the 16-bit output scale. A select code of zero keeps all 16 bits. A nonzero code `c` drops output bits `c` down to 0, which leaves `15-c` active bits.

Top module: `rsf_stage`

## Requirements
- R1: With `oe_n` low, `out_drv` is 16'hFFFF when `rnd_sel` is 0. For `rnd_sel` = c with c from 1 to 7, bits c down to 0 of `out_drv` are 0 and every bit above c is 1, so the active width is 16 when c is 0 and 15-c otherwise.
- R2: While `oe_n` is high, `out_drv` is all zeros. This takes effect in the same cycle, with no clock edge needed.
- R3: Let k be 0 when `rnd_sel` is 0 and `rnd_sel`+1 otherwise. The value kept is floor((A + 2^(D-1)) / 2^D), where A is the signed accumulator and D = `FRAC_W`+k, so rounding is half-up. This value is placed in the active bits, and output bits below bit k are 0.
- R4: The kept value is clamped to the signed range of the active width, 15-k+1 bits, instead of wrapping. A positive accumulator therefore never yields a negative two's complement output.
- R5: With `tc_fmt` high, the active bits hold the kept value in two's complement.
- R6: With `tc_fmt` low and `rnd_sel` nonzero, the output is unsigned. It equals the two's complement word with bit 15 inverted.
- R7: With `tc_fmt` low and `rnd_sel` zero, the output is inverted offset binary. It equals the two's complement word with bits 14 to 0 inverted and bit 15 kept.
- R8: `out_word` is registered. The inputs present at a rising edge determine `out_word` after that edge. Bits below the active field are 0 in the register.
- R9: While `rst_n` is low, `out_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_in | input | ACC_W | Signed accumulator value, FRAC_W fraction bits |
| rnd_sel | input | 3 | Rounding position / active width select |
| tc_fmt | input | 1 | 1: two's complement, 0: unsigned or inverted offset binary |
| oe_n | input | 1 | Asynchronous active-low output enable for the drive mask |
| out_word | output | 16 | Registered formatted output word |
| out_drv | output | 16 | Per-bit drive enable mask, 1 = driven |

## Verification
The bench builds the stage with `ACC_W` = 22 and `FRAC_W` = 3. With only 22 accumulator bits, both the largest and the smallest accumulator values can be driven directly, and these overflow every active width, so saturation at the 8-bit and 16-bit ends is hit on purpose. The small fraction field makes the exact half-LSB tie points easy to target: positive ties round up and negative ties round toward zero. Random draws mix full-range values with values near the output scale, so that unclamped rounding, clamping and all three formats occur for every select code.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    localparam int OUT_W = 16;
    localparam int SEL_W = 3;

    typedef logic [OUT_W-1:0] word_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        FMT_TWOS       = 2'd0,
        FMT_UNSIGNED   = 2'd1,
        FMT_OFFSET_INV = 2'd2
    } fmt_e;

    // Number of low output bits removed for a select code.
    function automatic int drop_bits(input sel_t code);
        return (code == '0) ? 0 : int'(code) + 1;
    endfunction

endpackage

// File: rtl/rsf_round.sv
module rsf_round
    import rsf_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int FRAC_W = 4
) (
    input  logic signed [ACC_W-1:0] acc,
    input  sel_t                    code,
    output logic signed [ACC_W:0]   kept
);

    localparam int EXT_W = ACC_W + 1;

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] bias;
    logic signed [EXT_W-1:0] sum;
    int                      dshift;

    always_comb begin
        dshift = FRAC_W + drop_bits(code);
        ext    = {acc[ACC_W-1], acc};
        bias   = '0;
        if (dshift > 0) begin
            bias[dshift-1] = 1'b1;
        end
        sum  = ext + bias;
        kept = sum >>> dshift;
    end

endmodule

// File: rtl/rsf_sat.sv
module rsf_sat
    import rsf_pkg::*;
#(
    parameter int IN_W = 25
) (
    input  logic signed [IN_W-1:0] val,
    input  sel_t                   code,
    output word_t                  placed
);

    logic signed [IN_W-1:0] hi_lim;
    logic signed [IN_W-1:0] lo_lim;
    logic signed [IN_W-1:0] clamp;
    int                     kdrop;
    int                     act_w;

    always_comb begin
        kdrop  = drop_bits(code);
        act_w  = OUT_W - kdrop;
        hi_lim = '0;
        for (int i = 0; i < OUT_W - 1; i++) begin
            if (i < act_w - 1) begin
                hi_lim[i] = 1'b1;
            end
        end
        lo_lim = ~hi_lim;
        if (val > hi_lim) begin
            clamp = hi_lim;
        end else if (val < lo_lim) begin
            clamp = lo_lim;
        end else begin
            clamp = val;
        end
        placed = clamp[OUT_W-1:0] << kdrop;
    end

endmodule

// File: rtl/rsf_fmt.sv
module rsf_fmt
    import rsf_pkg::*;
(
    input  word_t w,
    input  fmt_e  mode,
    output word_t y
);

    localparam word_t MSB_ONLY = word_t'(1) << (OUT_W - 1);

    always_comb begin
        unique case (mode)
            FMT_TWOS:       y = w;
            FMT_UNSIGNED:   y = w ^ MSB_ONLY;
            FMT_OFFSET_INV: y = w ^ ~MSB_ONLY;
            default:        y = w;
        endcase
    end

endmodule

// File: rtl/rsf_drive.sv
module rsf_drive
    import rsf_pkg::*;
(
    input  sel_t  code,
    input  logic  oe_n,
    output word_t drv
);

    for (genvar b = 0; b < OUT_W; b++) begin : g_bit
        assign drv[b] = !oe_n && ((code == '0) || (b > int'(code)));
    end

endmodule

// File: rtl/rsf_stage.sv
module rsf_stage
    import rsf_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [2:0]       rnd_sel,
    input  logic             tc_fmt,
    input  logic             oe_n,
    output logic [15:0]      out_word,
    output logic [15:0]      out_drv
);

    localparam int KEPT_W = ACC_W + 1;

    logic signed [KEPT_W-1:0] kept;
    word_t                    placed;
    word_t                    formatted;
    fmt_e                     mode;

    always_comb begin
        if (tc_fmt) begin
            mode = FMT_TWOS;
        end else if (rnd_sel != '0) begin
            mode = FMT_UNSIGNED;
        end else begin
            mode = FMT_OFFSET_INV;
        end
    end

    rsf_round #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) round_i (
        .acc  ($signed(acc_in)),
        .code (rnd_sel),
        .kept (kept)
    );

    rsf_sat #(.IN_W(KEPT_W)) sat_i (
        .val    (kept),
        .code   (rnd_sel),
        .placed (placed)
    );

    rsf_fmt fmt_i (
        .w    (placed),
        .mode (mode),
        .y    (formatted)
    );

    rsf_drive drive_i (
        .code (rnd_sel),
        .oe_n (oe_n),
        .drv  (out_drv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word <= '0;
        end else begin
            out_word <= formatted;
        end
    end

endmodule

// File: rtl/rsf_stage_chk.sv
module rsf_stage_chk #(
    parameter int ACC_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] acc_in,
    input logic [2:0]       rnd_sel,
    input logic             tc_fmt,
    input logic             oe_n,
    input logic [15:0]      out_word,
    input logic [15:0]      out_drv
);

    // R2: disabled enable clears every driver
    p_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (out_drv == 16'h0000));

    // R1: top byte is always active when enabled
    p_top_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (out_drv[15:8] == 8'hFF));

    // R1: driven bits form one field anchored at bit 15
    p_mask_contig_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (((~out_drv) & ((~out_drv) + 16'd1)) == 16'h0000));

    // R8: bits below the active field are zero in the register
    p_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && rnd_sel == $past(rnd_sel)) |=> ((out_word & ~$past(out_drv)) == 16'h0000));

    // R4: positive input never wraps to a negative two's complement word
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_fmt && !acc_in[ACC_W-1]) |=> !out_word[15]);

endmodule

bind rsf_stage rsf_stage_chk #(.ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_in   (acc_in),
    .rnd_sel  (rnd_sel),
    .tc_fmt   (tc_fmt),
    .oe_n     (oe_n),
    .out_word (out_word),
    .out_drv  (out_drv)
);

// File: tb/rsf_stage_tb.sv
module rsf_stage_tb_top;

    localparam int  CLK_P  = 10;
    localparam int  ACC_W  = 22;
    localparam int  FRAC_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ACC_W-1:0] acc_in = '0;
    logic [2:0]       rnd_sel = '0;
    logic             tc_fmt = 1'b1;
    logic             oe_n = 1'b0;
    logic [15:0]      out_word;
    logic [15:0]      out_drv;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    rsf_stage #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_in   (acc_in),
        .rnd_sel  (rnd_sel),
        .tc_fmt   (tc_fmt),
        .oe_n     (oe_n),
        .out_word (out_word),
        .out_drv  (out_drv)
    );

    function automatic logic [15:0] exp_mask(input int code, input bit off);
        if (off) return 16'h0000;
        if (code == 0) return 16'hFFFF;
        return 16'hFFFF << (code + 1);
    endfunction

    function automatic logic [15:0] exp_word(input longint a, input int code, input bit fmt);
        int          k;
        int          d;
        longint      r;
        longint      hi;
        longint      lo;
        logic [15:0] v;
        k = (code == 0) ? 0 : code + 1;
        d = FRAC_W + k;
        r = a;
        if (d > 0) r = r + (longint'(1) <<< (d - 1));
        r = r >>> d;
        hi = (longint'(1) <<< (15 - k)) - 1;
        lo = -hi - 1;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        v = 16'(r) << k;
        if (fmt) return v;
        if (code != 0) return v ^ 16'h8000;
        return v ^ 16'h7FFF;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Applies one input set, checks the mask at once and the word after the edge.
    task automatic apply(input logic [ACC_W-1:0] a, input int code, input bit fmt, input string tag);
        @(negedge clk);
        acc_in  = a;
        rnd_sel = 3'(code);
        tc_fmt  = fmt;
        #1;
        check("R1 mask", out_drv, exp_mask(code, oe_n));
        @(negedge clk);
        check(tag, out_word, exp_word(longint'($signed(a)), code, fmt));
    endtask

    task automatic apply_lit(input logic [ACC_W-1:0] a, input int code, input bit fmt,
                             input logic [15:0] lit, input string tag);
        apply(a, code, fmt, tag);
        check(tag, out_word, lit);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [ACC_W-1:0] maxv;
        logic [ACC_W-1:0] minv;
        maxv = {1'b0, {(ACC_W-1){1'b1}}};
        minv = {1'b1, {(ACC_W-1){1'b0}}};

        repeat (3) @(negedge clk);
        check("R9 reset word", out_word, 16'h0000);
        check("R1 reset mask", out_drv, 16'hFFFF);
        rst_n = 1'b1;

        // R4 saturation at both ends of the 8-bit and 16-bit widths
        apply_lit(maxv, 7, 1'b1, 16'h7F00, "R4 max w8");
        apply_lit(minv, 7, 1'b1, 16'h8000, "R4 min w8");
        apply_lit(maxv, 0, 1'b1, 16'h7FFF, "R4 max w16");
        apply_lit(minv, 0, 1'b1, 16'h8000, "R4 min w16");
        // R3 half-up rounding ties
        apply_lit(22'd4, 0, 1'b1, 16'h0001, "R3 pos tie");
        apply_lit(22'd3, 0, 1'b1, 16'h0000, "R3 below tie");
        apply_lit(-22'sd4, 0, 1'b1, 16'h0000, "R3 neg tie");
        apply_lit(-22'sd5, 0, 1'b1, 16'hFFFF, "R3 below neg tie");
        apply_lit(22'd16, 1, 1'b1, 16'h0004, "R3 code1 tie");
        // R5 R6 R7 formats
        apply_lit(22'd8, 0, 1'b1, 16'h0001, "R5 twos");
        apply_lit(22'd0, 3, 1'b0, 16'h8000, "R6 unsigned zero");
        apply_lit(minv, 3, 1'b0, 16'h0000, "R6 unsigned min");
        apply_lit(22'd0, 0, 1'b0, 16'h7FFF, "R7 offset zero");
        apply_lit(maxv, 0, 1'b0, 16'h0000, "R7 offset max");

        // R2 asynchronous disable, no clock edge between change and check
        @(negedge clk);
        #2;
        oe_n = 1'b1;
        #1;
        check("R2 async off", out_drv, 16'h0000);
        oe_n = 1'b0;
        #1;
        check("R2 async on", out_drv, exp_mask(int'(rnd_sel), 1'b0));
        apply(22'd100, 5, 1'b1, "R8 with oe");
        oe_n = 1'b1;
        apply(22'd100, 2, 1'b1, "R2 word kept while off");
        oe_n = 1'b0;

        // R1 every code
        for (int c = 0; c < 8; c++) begin
            apply(22'd1234, c, 1'b1, "R1 sweep");
        end

        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            logic [ACC_W-1:0] a;
            longint           v;
            int               cls;
            cls = int'($urandom_range(0, 2));
            if (cls == 0) begin
                a = ACC_W'($urandom);
            end else begin
                v = longint'($urandom_range(0, 32'd1 << (FRAC_W + 17))) - (longint'(1) <<< (FRAC_W + 16));
                a = ACC_W'(v);
            end
            apply(a, int'($urandom_range(0, 7)), 1'($urandom), "R3 R4 R5 R6 R7 random");
        end

        // R9 reset clears the register again
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async reset", out_word, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule